// File: doc/BRIEF.md
# Error-Tagged Receive Queue with Line Status

This block is the receive-side storage of a 16550-style UART. A receive shifter hands it one assembled character at a time, together with that character's parity and framing flags, or a single break strobe. The block masks the character to the configured word length, packs it with an error tag and queues it. A byte-wide register bus reads the oldest character through the receive buffer register (RBR) and the line status register (LSR). The same bus can flush the queue through a write to the FIFO control register (FCR).

An error never shows up in the LSR when its character arrives. It stays in the tag beside the character and is merged into the LSR only once that character is the oldest entry. The tag is then wiped from the entry, so an LSR read can clear the bits for good. Overrun is the one exception. It has no character to travel with, so it is set in the LSR at once.

The queue's fill tracking is a small state machine with three states: `FILL_EMPTY`, `FILL_PART` and `FILL_FULL`. The transitions are:
- *first push*: EMPTY to PART.
- *fill up*: PART to FULL, when the count reaches the depth.
- *drain*: PART to EMPTY, when the count reaches zero.
- *free slot*: FULL to PART, on a pop.
- *flush*: any state to EMPTY, or to PART when a character arrives in the same cycle.

Top module: `rx_tagged_fifo`

## Requirements
- R1: After reset the LSR reads 0x60 when both transmitter-empty inputs are high (bit 5 = `thr_empty`, bit 6 = `tx_idle`). `data_ready` is 0 and `tmo_restart` is 0.
- R2: Reading address 0 (RBR) returns the oldest stored character and removes it, so characters leave in arrival order. LSR bit 0 and `data_ready` are 1 exactly while at least one entry is held. An empty queue reads RBR as 0.
- R3: A stored character keeps only its low 5 + `wlen` bits, and the bits above are zero. For example, 0xFF reads back as 0x1F when `wlen` = 0 and as 0x7F when `wlen` = 2.
- R4: A character's error tag is formed when it arrives. Parity gives bit 2 plus bit 7, and framing gives bit 3 plus bit 7. The tag reaches the LSR one cycle after that entry becomes the head, and never earlier while older entries are still queued.
- R5: A head tag is merged only once. After an LSR read has cleared the bits, the same head entry does not set them again.
- R6: A character that arrives while the queue is full is dropped, and LSR bits 1 and 7 are set on the next clock. The queued characters are kept unchanged.
- R7: A break strobe stores the character 0x00 with a tag of bits 4, 3 and 7, plus bit 2 when `par_en` is 1. With both transmitter-empty inputs high, this reads as LSR 0xF9, or 0xFD with parity enabled.
- R8: An LSR read (address 5) clears LSR bits 1 to 4 and 7. After a break entry has been merged, a read leaves LSR at 0x61 while that entry is still held.
- R9: A write to address 2 (FCR) with data bit 1 set empties the queue and clears data-ready. A write to that address with bit 1 clear changes nothing.
- R10: `tmo_restart` pulses high for exactly one cycle, one clock after each received character or break, whether the character was stored or dropped.
- R11: A break and a character strobe in the same cycle store only the break entry. A flush and a character arriving in the same cycle leave exactly that character queued.
- R12: A character with a framing error, received with both transmitter-empty inputs high, makes the LSR read 0xE9 once the character is at the head.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| rx_stb | input | 1 | An assembled character is present this cycle |
| rx_byte | input | 8 | Assembled character |
| rx_perr | input | 1 | Parity error on this character |
| rx_ferr | input | 1 | Framing error on this character |
| brk_stb | input | 1 | A break condition was detected this cycle |
| wlen | input | 2 | Word length select; the character has 5 + wlen bits |
| par_en | input | 1 | Parity is enabled in the line configuration |
| thr_empty | input | 1 | Transmit holding register empty, shown as LSR bit 5 |
| tx_idle | input | 1 | Transmitter fully idle, shown as LSR bit 6 |
| bus_rd | input | 1 | Register read strobe; side effects apply at the clock edge |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 3 | Register address: 0 RBR, 2 FCR, 5 LSR |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr`; combinational, with no side effect unless `bus_rd` is high |
| data_ready | output | 1 | At least one character is queued |
| tmo_restart | output | 1 | One-cycle pulse that restarts the character-timeout counter |

## Verification
Several internal faults show up at the ports with a delay:
- A tag that is lost or moved to the wrong entry shows as a wrong LSR value. This appears one cycle after the affected character reaches the head, which can be many reads after it arrived.
- A tag that is not wiped after its merge shows only after an LSR read, when the cleared error bits come straight back.
- A fill-state error near the full boundary shows as a missing overrun flag, as a character that was silently overwritten and reappears out of order, or as `data_ready` falling one read too early or too late.

The bench keeps a behavioural queue model and compares `bus_rdata`, `data_ready` and `tmo_restart` on every cycle. It also checks fixed LSR values at the moments these faults would first become visible.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    // LSR bit positions (software decodes these, so positions are fixed)
    localparam int LSR_DR   = 0;
    localparam int LSR_OE   = 1;
    localparam int LSR_PE   = 2;
    localparam int LSR_FE   = 3;
    localparam int LSR_BI   = 4;
    localparam int LSR_THRE = 5;
    localparam int LSR_TEMT = 6;
    localparam int LSR_ERR  = 7;

    // bits of the LSR that an LSR read clears and a tag may set
    localparam logic [7:0] ERR_BITS = 8'h9E;

    typedef enum logic [1:0] {
        FILL_EMPTY,
        FILL_PART,
        FILL_FULL
    } fill_e;

    typedef struct packed {
        logic [7:0] tag;
        logic [7:0] chr;
    } entry_t;

endpackage

// File: rtl/rxq_tagger.sv
module rxq_tagger
    import rxq_pkg::*;
(
    input  logic       rx_stb,
    input  logic [7:0] rx_byte,
    input  logic       rx_perr,
    input  logic       rx_ferr,
    input  logic       brk_stb,
    input  logic [1:0] wlen,
    input  logic       par_en,
    output logic       evt,
    output entry_t     ent
);

    logic [7:0] len_mask;

    always_comb begin
        len_mask = 8'hFF >> (2'd3 - wlen);
        evt      = rx_stb | brk_stb;
        ent      = '0;
        if (brk_stb) begin
            // break wins over a simultaneous character strobe
            ent.chr          = 8'h00;
            ent.tag[LSR_BI]  = 1'b1;
            ent.tag[LSR_FE]  = 1'b1;
            ent.tag[LSR_PE]  = par_en;
            ent.tag[LSR_ERR] = 1'b1;
        end else if (rx_stb) begin
            ent.chr          = rx_byte & len_mask;
            ent.tag[LSR_PE]  = rx_perr;
            ent.tag[LSR_FE]  = rx_ferr;
            ent.tag[LSR_ERR] = rx_perr | rx_ferr;
        end
    end

endmodule

// File: rtl/rxq_store.sv
module rxq_store
    import rxq_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic   clk,
    input  logic   rst_n,
    input  logic   flush,
    input  logic   push,
    input  entry_t push_ent,
    input  logic   pop,
    input  logic   tag_clr,
    output entry_t head,
    output logic   not_empty,
    output logic   full
);

    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

    entry_t        mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count, count_nx;
    fill_e         fill_q, fill_nx;
    logic          acc_push, do_pop;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == LAST) ? '0 : p + 1'b1;
    endfunction

    always_comb begin
        acc_push = push & (flush | (fill_q != FILL_FULL));
        do_pop   = pop & (fill_q != FILL_EMPTY) & ~flush;
        if (flush)
            count_nx = CW'(acc_push);
        else
            count_nx = count + CW'(acc_push) - CW'(do_pop);
    end

    // next fill state
    always_comb begin
        fill_nx = fill_q;
        unique case (fill_q)
            FILL_EMPTY: fill_nx = acc_push ? FILL_PART : FILL_EMPTY;
            FILL_PART: begin
                if (count_nx == '0)                 fill_nx = FILL_EMPTY;
                else if (count_nx == CW'(DEPTH))    fill_nx = FILL_FULL;
                else                                fill_nx = FILL_PART;
            end
            FILL_FULL: begin
                if (flush)       fill_nx = acc_push ? FILL_PART : FILL_EMPTY;
                else if (do_pop) fill_nx = FILL_PART;
                else             fill_nx = FILL_FULL;
            end
            default: fill_nx = FILL_EMPTY;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fill_q <= FILL_EMPTY;
            count  <= '0;
            wr_ptr <= '0;
            rd_ptr <= '0;
        end else begin
            fill_q <= fill_nx;
            count  <= count_nx;
            if (flush) begin
                rd_ptr <= '0;
                wr_ptr <= acc_push ? bump('0) : '0;
            end else begin
                if (acc_push) wr_ptr <= bump(wr_ptr);
                if (do_pop)   rd_ptr <= bump(rd_ptr);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (tag_clr && !flush)
            mem[rd_ptr].tag <= '0;
        if (acc_push)
            mem[flush ? '0 : wr_ptr] <= push_ent;
    end

    // outputs
    always_comb begin
        head      = mem[rd_ptr];
        not_empty = (fill_q != FILL_EMPTY);
        full      = (fill_q == FILL_FULL);
    end

    assert_no_overflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !flush && !pop) |=> (count == CW'(DEPTH)));

    assert_flush_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (flush && !push) |=> !not_empty);

    assert_tag_once_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tag_clr && !pop && !flush) |=> (head.tag == 8'h00));

endmodule

// File: rtl/rxq_status.sv
module rxq_status
    import rxq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       merge,
    input  logic [7:0] head_tag,
    input  logic       ovr_set,
    input  logic       lsr_rd,
    output logic [7:0] err_bits
);

    logic [7:0] err_q, err_nx, ovr_bits;

    always_comb begin
        ovr_bits          = '0;
        ovr_bits[LSR_OE]  = 1'b1;
        ovr_bits[LSR_ERR] = 1'b1;
        err_nx = lsr_rd ? 8'h00 : err_q;
        if (merge)   err_nx = err_nx | (head_tag & ERR_BITS);
        if (ovr_set) err_nx = err_nx | ovr_bits;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) err_q <= '0;
        else        err_q <= err_nx;
    end

    assign err_bits = err_q;

    assert_read_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (lsr_rd && !merge && !ovr_set) |=> (err_bits == 8'h00));

    assert_merge_lands_R4: assert property (@(posedge clk) disable iff (!rst_n)
        merge |=> ((err_bits & $past(head_tag & ERR_BITS)) == $past(head_tag & ERR_BITS)));

    assert_overrun_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_set |=> (err_bits[LSR_OE] && err_bits[LSR_ERR]));

endmodule

// File: rtl/rx_tagged_fifo.sv
module rx_tagged_fifo
    import rxq_pkg::*;
#(
    parameter int DEPTH     = 16,
    parameter int ADDR_W    = 3,
    parameter int A_RBR     = 0,
    parameter int A_FCR     = 2,
    parameter int A_LSR     = 5,
    parameter int FCR_RXCLR = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_stb,
    input  logic [7:0]        rx_byte,
    input  logic              rx_perr,
    input  logic              rx_ferr,
    input  logic              brk_stb,
    input  logic [1:0]        wlen,
    input  logic              par_en,
    input  logic              thr_empty,
    input  logic              tx_idle,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic              data_ready,
    output logic              tmo_restart
);

    localparam logic [ADDR_W-1:0] AD_RBR = ADDR_W'(A_RBR);
    localparam logic [ADDR_W-1:0] AD_FCR = ADDR_W'(A_FCR);
    localparam logic [ADDR_W-1:0] AD_LSR = ADDR_W'(A_LSR);

    logic       evt, flush, pop, lsr_rd, ovr_set, merge;
    logic       q_nonempty, q_full;
    entry_t     new_ent, head;
    logic [7:0] err_bits, lsr_val;
    logic       tmo_q;
    logic [7:0] unused_wdata;

    assign unused_wdata = bus_wdata;

    rxq_tagger u_tag (
        .rx_stb  (rx_stb),
        .rx_byte (rx_byte),
        .rx_perr (rx_perr),
        .rx_ferr (rx_ferr),
        .brk_stb (brk_stb),
        .wlen    (wlen),
        .par_en  (par_en),
        .evt     (evt),
        .ent     (new_ent)
    );

    always_comb begin
        flush   = bus_wr & (bus_addr == AD_FCR) & bus_wdata[FCR_RXCLR];
        pop     = bus_rd & (bus_addr == AD_RBR);
        lsr_rd  = bus_rd & (bus_addr == AD_LSR);
        ovr_set = evt & q_full & ~flush;
        merge   = q_nonempty & (head.tag != 8'h00);
    end

    rxq_store #(.DEPTH(DEPTH)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (flush),
        .push      (evt),
        .push_ent  (new_ent),
        .pop       (pop),
        .tag_clr   (merge),
        .head      (head),
        .not_empty (q_nonempty),
        .full      (q_full)
    );

    rxq_status u_status (
        .clk      (clk),
        .rst_n    (rst_n),
        .merge    (merge),
        .head_tag (head.tag),
        .ovr_set  (ovr_set),
        .lsr_rd   (lsr_rd),
        .err_bits (err_bits)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) tmo_q <= 1'b0;
        else        tmo_q <= evt;
    end

    always_comb begin
        lsr_val           = err_bits;
        lsr_val[LSR_DR]   = q_nonempty;
        lsr_val[LSR_THRE] = thr_empty;
        lsr_val[LSR_TEMT] = tx_idle;
        if (bus_addr == AD_LSR)      bus_rdata = lsr_val;
        else if (bus_addr == AD_RBR) bus_rdata = q_nonempty ? head.chr : 8'h00;
        else                         bus_rdata = 8'h00;
    end

    assign data_ready  = q_nonempty;
    assign tmo_restart = tmo_q;

    assert_arrival_ready_R2: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> data_ready);

    assert_pulse_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (tmo_restart && !$past(evt)) |-> 1'b0);

endmodule

// File: tb/test_rx_tagged_fifo.sv
module test_rx_tagged_fifo;

    localparam int DEPTH = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_stb = 0, rx_perr = 0, rx_ferr = 0, brk_stb = 0, par_en = 0;
    logic [7:0] rx_byte = 0, bus_wdata = 0;
    logic [1:0] wlen = 2'd3;
    logic       thr_empty = 1, tx_idle = 1, bus_rd = 0, bus_wr = 0;
    logic [2:0] bus_addr = 3'd5;
    logic [7:0] bus_rdata;
    logic       data_ready, tmo_restart;

    int    n_chk = 0, n_bad = 0;
    bit    cmp_on = 0;
    string phase = "R1";

    int q[$];
    int merr = 0;
    bit exp_tmo = 0;

    always #4 clk = ~clk;

    rx_tagged_fifo #(.DEPTH(DEPTH)) i_rx_tagged_fifo (
        .clk(clk), .rst_n(rst_n), .rx_stb(rx_stb), .rx_byte(rx_byte),
        .rx_perr(rx_perr), .rx_ferr(rx_ferr), .brk_stb(brk_stb), .wlen(wlen),
        .par_en(par_en), .thr_empty(thr_empty), .tx_idle(tx_idle),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .data_ready(data_ready), .tmo_restart(tmo_restart)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic model_step();
        bit rd_l, rd_r, fl, full0, has_ev;
        int mt, ev, msk;
        rd_l  = bus_rd && bus_addr == 3'd5;
        rd_r  = bus_rd && bus_addr == 3'd0;
        fl    = bus_wr && bus_addr == 3'd2 && bus_wdata[1];
        full0 = (q.size() == DEPTH);
        mt    = 0;
        if (q.size() > 0) begin
            mt   = (q[0] >> 8) & 'h9E;
            q[0] = q[0] & 'hFF;
        end
        merr = (rd_l ? 0 : merr) | mt;
        if (fl) q.delete();
        else if (rd_r && q.size() > 0) void'(q.pop_front());
        has_ev = 0;
        ev     = 0;
        msk    = 'hFF >> (3 - int'(wlen));
        if (brk_stb) begin
            has_ev = 1;
            ev = ('h98 | (par_en ? 'h04 : 0)) << 8;
        end else if (rx_stb) begin
            has_ev = 1;
            ev = (((rx_perr ? 'h84 : 0) | (rx_ferr ? 'h88 : 0)) << 8) | (int'(rx_byte) & msk);
        end
        if (has_ev) begin
            if (!fl && full0) merr = merr | 'h82;
            else q.push_back(ev);
        end
        exp_tmo = has_ev;
    endtask

    function automatic int exp_rdata();
        if (bus_addr == 3'd5)
            return merr | (int'(tx_idle) << 6) | (int'(thr_empty) << 5) | ((q.size() != 0) ? 1 : 0);
        if (bus_addr == 3'd0)
            return (q.size() != 0) ? (q[0] & 'hFF) : 0;
        return 0;
    endfunction

    // cycle-by-cycle comparison against the behavioural model
    always @(posedge clk) begin
        if (!rst_n) begin
            q.delete();
            merr    = 0;
            exp_tmo = 0;
        end else begin
            model_step();
        end
        #3;
        if (cmp_on) begin
            chk({phase, " model rdata"}, int'(bus_rdata), exp_rdata());
            chk({phase, " model data_ready"}, int'(data_ready), (q.size() != 0) ? 1 : 0);
            chk({phase, " model tmo_restart R10"}, int'(tmo_restart), int'(exp_tmo));
        end
    end

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic send(input logic [7:0] b, input bit pe, input bit fe);
        rx_stb = 1; rx_byte = b; rx_perr = pe; rx_ferr = fe;
        tick();
        rx_stb = 0; rx_perr = 0; rx_ferr = 0;
    endtask

    task automatic send_brk();
        brk_stb = 1;
        tick();
        brk_stb = 0;
    endtask

    task automatic rd_reg(input logic [2:0] a, output logic [7:0] v);
        bus_addr = a; bus_rd = 1;
        #1 v = bus_rdata;
        tick();
        bus_rd = 0; bus_addr = 3'd5;
    endtask

    task automatic wr_fcr(input logic [7:0] d);
        bus_addr = 3'd2; bus_wr = 1; bus_wdata = d;
        tick();
        bus_wr = 0; bus_addr = 3'd5;
    endtask

    task automatic peek(output logic [7:0] v);
        bus_addr = 3'd5;
        #1 v = bus_rdata;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (3) tick();
        rst_n = 1;
        tick();
        cmp_on = 1;

        phase = "R1";
        peek(v); chk("R1 reset LSR", v, 'h60);
        chk("R1 reset data_ready", data_ready, 0);
        chk("R1 reset tmo_restart", tmo_restart, 0);

        phase = "R2";
        send("A", 0, 0); send("B", 0, 0); send("C", 0, 0);
        chk("R2 data_ready held", data_ready, 1);
        rd_reg(3'd0, v); chk("R2 first out", v, "A");
        rd_reg(3'd0, v); chk("R2 second out", v, "B");
        rd_reg(3'd0, v); chk("R2 third out", v, "C");
        peek(v); chk("R2 drained LSR", v, 'h60);
        rd_reg(3'd0, v); chk("R2 empty RBR", v, 0);

        phase = "R3";
        wlen = 2'd0; send(8'hFF, 0, 0);
        rd_reg(3'd0, v); chk("R3 5-bit mask", v, 'h1F);
        wlen = 2'd2; send(8'hFF, 0, 0);
        rd_reg(3'd0, v); chk("R3 7-bit mask", v, 'h7F);
        wlen = 2'd3;

        phase = "R4";
        send("x", 0, 0); send("y", 1, 0);
        peek(v); chk("R4 tag held back", v, 'h61);
        rd_reg(3'd0, v); chk("R4 clean head", v, "x");
        peek(v); chk("R4 not merged yet", v, 'h61);
        tick();
        peek(v); chk("R4 parity merged", v, 'hE5);

        phase = "R5";
        rd_reg(3'd5, v); chk("R8 read shows errors", v, 'hE5);
        peek(v); chk("R5 no re-tag", v, 'h61);
        tick();
        peek(v); chk("R5 still clear", v, 'h61);
        rd_reg(3'd0, v); chk("R5 tagged char", v, "y");

        phase = "R12";
        send("c", 0, 1); tick();
        peek(v); chk("R12 framing LSR", v, 'hE9);
        rd_reg(3'd5, v);
        rd_reg(3'd0, v); chk("R12 char", v, "c");

        phase = "R6";
        for (int i = 0; i < DEPTH; i++) send(8'(i + 'h20), 0, 0);
        chk("R6 full no overrun", bus_rdata, 'h61);
        send(8'h55, 0, 0);
        peek(v); chk("R6 overrun LSR", v, 'hE3);
        for (int i = 0; i < DEPTH; i++) begin
            rd_reg(3'd0, v); chk("R6 kept order", v, i + 'h20);
        end
        peek(v); chk("R6 dropped char gone", v, 'hE2);
        rd_reg(3'd5, v);
        peek(v); chk("R8 overrun cleared", v, 'h60);

        phase = "R7";
        par_en = 1; send_brk(); tick();
        peek(v); chk("R7 break with parity", v, 'hFD);
        rd_reg(3'd5, v);
        peek(v); chk("R8 break read clears", v, 'h61);
        rd_reg(3'd0, v); chk("R7 break char zero", v, 0);
        par_en = 0; send_brk(); tick();
        peek(v); chk("R7 break no parity", v, 'hF9);
        rd_reg(3'd5, v);
        rd_reg(3'd0, v);

        phase = "R9";
        send("1", 0, 0); send("2", 0, 0);
        wr_fcr(8'h01);
        peek(v); chk("R9 bit1 clear ignored", v, 'h61);
        wr_fcr(8'h02);
        peek(v); chk("R9 flush LSR", v, 'h60);
        chk("R9 flush data_ready", data_ready, 0);

        phase = "R10";
        send("t", 0, 0);
        chk("R10 pulse high", tmo_restart, 1);
        tick();
        chk("R10 pulse one cycle", tmo_restart, 0);
        rd_reg(3'd0, v);

        phase = "R11";
        rx_stb = 1; rx_byte = 8'h41; brk_stb = 1;
        tick();
        rx_stb = 0; brk_stb = 0;
        tick();
        peek(v); chk("R11 break wins", v, 'hF9);
        rd_reg(3'd5, v);
        rd_reg(3'd0, v); chk("R11 break entry", v, 0);
        peek(v); chk("R11 single entry", v, 'h60);
        send("p", 0, 0); send("q", 0, 0);
        bus_addr = 3'd2; bus_wr = 1; bus_wdata = 8'h02;
        rx_stb = 1; rx_byte = 8'h4B;
        tick();
        bus_wr = 0; rx_stb = 0; bus_addr = 3'd5;
        peek(v); chk("R11 flush keeps new", v, 'h61);
        rd_reg(3'd0, v); chk("R11 flush char", v, 'h4B);
        peek(v); chk("R11 flush only one", v, 'h60);

        tick();
        $display("test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule